// File: doc/BRIEF.md
# GPIO controller with edge capture

This block is a register-mapped general-purpose I/O controller for up to 32 pins. The pin count is a build parameter that defaults to 32. Software uses a single-cycle register port to do four things: set output values, pick the direction of each pin, enable interrupts per pin, and collect edges that were captured on the pins. The block drives a per-pin output value and a per-pin output enable for an external tri-state pad. It raises one interrupt line.

Each input pin is synchronised through two flops. The block then compares the synchronised value with its value one cycle earlier. The trigger type is fixed at build time and is one of four: rising edge, falling edge, either edge, or level high. In the three edge modes, each detected edge sets a sticky capture bit. Software clears a capture bit by writing a one to it. In level mode there is no capture state, and the interrupt follows the synchronised pins directly through the mask.

Top module: `gpio_cap`

## Requirements
- R1: After reset, the following all hold: the output, direction, mask and capture registers are zero, pin_oe is zero, irq is low and reg_rdata is zero.
- R2: The register is chosen by the exact byte address. 0x0 is data, 0x4 is direction, 0x8 is mask and 0xC is capture. A read sampled with reg_re at clock edge k shows the register's value from before edge k on reg_rdata after edge k, and reg_rdata holds while reg_re is low. Writes to any other address are ignored, and reads from any other address return zero.
- R3: A write to direction or data takes effect at that clock edge. pin_oe follows the direction register, with 1 meaning output. pin_out follows the data register.
- R4: A data read returns a mix of sources. Bits whose direction is 1 return the written output value. Bits whose direction is 0 return pin_in, and a pin_in change applied before edge k is visible to a read sampled at edge k+2 or later.
- R5: Edges are detected on the synchronised pin_in of every pin, whatever its direction. Rising mode captures 0-to-1 transitions, falling mode captures 1-to-0 transitions and both-edge mode captures either. A transition applied before edge k sets its capture bit at edge k+2.
- R6: A capture bit stays set until a write to 0xC carries a 1 in that position. Writing 0 to a bit leaves it unchanged.
- R7: If a detected edge and a clearing write hit the same capture bit at the same clock edge, the bit ends up set.
- R8: In the edge modes, irq is high exactly while (capture AND mask) is nonzero, and it follows those registers with no extra delay.
- R9: In level mode, irq is high exactly while (synchronised pin_in AND mask) is nonzero. The capture register reads as zero, and writes to it have no effect.
- R10: Register bits at or above the pin count read as zero and ignore writes.
- R11: A mask bit of 0 keeps its pin from raising irq. With the mask at its reset value, irq stays low whatever the capture bits or the pins hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_we | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_re | input | 1 | Read strobe, sampled at the clock edge |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | N | Asynchronous pin inputs |
| pin_out | output | N | Output value per pin |
| pin_oe | output | N | Output enable per pin, 1 means output |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds one instance in each of the four trigger modes and drives them with 20 pins, which tests the bits above the pin count. It forces an edge and a clearing write onto the same capture bit in the same cycle: a design that let the clear win would lose that interrupt. It checks the capture timing cycle by cycle against a model, so a sync chain that is one flop too short or too long, or an edge detector that looks at the raw pin, shows up as a miscompare. It also checks that a capture bit survives a write of zero and that level mode neither holds nor accepts capture state: a design that cleared on any write, or that latched edges in level mode, would report the wrong interrupt.

// File: rtl/gpio_cap_pkg.sv
package gpio_cap_pkg;

   typedef enum logic [1:0] {
      TRIG_RISE  = 2'd0,
      TRIG_FALL  = 2'd1,
      TRIG_BOTH  = 2'd2,
      TRIG_LEVEL = 2'd3
   } trig_e;

   localparam int REG_W    = 32;
   localparam int MAX_PINS = 32;

   localparam logic [3:0] OFF_DATA = 4'h0;
   localparam logic [3:0] OFF_DIR  = 4'h4;
   localparam logic [3:0] OFF_MASK = 4'h8;
   localparam logic [3:0] OFF_CAP  = 4'hC;

   typedef struct packed {
      logic data;
      logic dir;
      logic mask;
      logic cap;
   } sel_t;

endpackage

// File: rtl/gpio_cap_dec.sv
module gpio_cap_dec
   import gpio_cap_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   output sel_t              sel
);

   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_cap_dec: ADDR_W must be at least 4");
   end

   // full compare: unaligned and out-of-window addresses select nothing
   assign sel.data = (addr == ADDR_W'(OFF_DATA));
   assign sel.dir  = (addr == ADDR_W'(OFF_DIR));
   assign sel.mask = (addr == ADDR_W'(OFF_MASK));
   assign sel.cap  = (addr == ADDR_W'(OFF_CAP));

endmodule

// File: rtl/gpio_cap_sync.sv
module gpio_cap_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_cap_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("gpio_cap_sync: W must be positive");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) begin
            chain_q[s] <= '0;
         end
      end else begin
         chain_q[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_cap_edge.sv
module gpio_cap_edge
   import gpio_cap_pkg::*;
#(
   parameter int    W    = 32,
   parameter trig_e MODE = TRIG_RISE
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_in,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] hit,
   output logic [W-1:0] cap_q
);

   if (MODE == TRIG_LEVEL) begin : g_bad_mode
      $error("gpio_cap_edge: level mode has no edge detector");
   end

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_in;
   end

   if (MODE == TRIG_RISE) begin : g_rise
      assign hit = sync_in & ~prev_q;
   end else if (MODE == TRIG_FALL) begin : g_fall
      assign hit = ~sync_in & prev_q;
   end else begin : g_both
      assign hit = sync_in ^ prev_q;
   end

   // new edge has priority over a clear landing on the same bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q <= '0;
      else        cap_q <= hit | (cap_q & ~clr_vec);
   end

endmodule

// File: rtl/gpio_cap_regs.sv
module gpio_cap_regs
   import gpio_cap_pkg::*;
#(
   parameter int W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sel_t             sel,
   input  logic             we,
   input  logic             re,
   input  logic [REG_W-1:0] wdata,
   input  logic [W-1:0]     sync_in,
   input  logic [W-1:0]     cap_q,
   output logic [W-1:0]     out_q,
   output logic [W-1:0]     dir_q,
   output logic [W-1:0]     mask_q,
   output logic [REG_W-1:0] rdata
);

   if (W < 1 || W > REG_W) begin : g_bad_width
      $error("gpio_cap_regs: W out of range");
   end

   logic [W-1:0] wbits;
   logic [W-1:0] rd_vec;

   assign wbits = wdata[W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
      end else if (we) begin
         if (sel.data) out_q  <= wbits;
         if (sel.dir)  dir_q  <= wbits;
         if (sel.mask) mask_q <= wbits;
      end
   end

   always_comb begin
      rd_vec = '0;
      if (sel.data) rd_vec = (dir_q & out_q) | (~dir_q & sync_in);
      if (sel.dir)  rd_vec = dir_q;
      if (sel.mask) rd_vec = mask_q;
      if (sel.cap)  rd_vec = cap_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= REG_W'(rd_vec);
   end

endmodule

// File: rtl/gpio_cap.sv
module gpio_cap
   import gpio_cap_pkg::*;
#(
   parameter int    N      = 32,
   parameter int    ADDR_W = 4,
   parameter trig_e MODE   = TRIG_RISE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   input  logic              reg_re,
   output logic [31:0]       reg_rdata,
   input  logic [N-1:0]      pin_in,
   output logic [N-1:0]      pin_out,
   output logic [N-1:0]      pin_oe,
   output logic              irq
);

   localparam int SYNC_STAGES = 2;

   if (N < 1 || N > MAX_PINS) begin : g_bad_pins
      $error("gpio_cap: N must be between 1 and MAX_PINS");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("gpio_cap: ADDR_W must be at least 4");
   end

   sel_t         sel;
   logic [N-1:0] sync_q;
   logic [N-1:0] out_q;
   logic [N-1:0] dir_q;
   logic [N-1:0] mask_q;
   logic [N-1:0] cap_q;
   logic [N-1:0] edge_hit;

   gpio_cap_dec #(.ADDR_W(ADDR_W)) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   gpio_cap_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (sync_q)
   );

   gpio_cap_regs #(.W(N)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel),
      .we      (reg_we),
      .re      (reg_re),
      .wdata   (reg_wdata),
      .sync_in (sync_q),
      .cap_q   (cap_q),
      .out_q   (out_q),
      .dir_q   (dir_q),
      .mask_q  (mask_q),
      .rdata   (reg_rdata)
   );

   if (MODE == TRIG_LEVEL) begin : g_level
      assign cap_q    = '0;
      assign edge_hit = '0;
      assign irq      = |(sync_q & mask_q);
   end else begin : g_edge
      logic [N-1:0] clr_vec;

      assign clr_vec = (reg_we && sel.cap) ? reg_wdata[N-1:0] : '0;

      gpio_cap_edge #(.W(N), .MODE(MODE)) u_edge (
         .clk     (clk),
         .rst_n   (rst_n),
         .sync_in (sync_q),
         .clr_vec (clr_vec),
         .hit     (edge_hit),
         .cap_q   (cap_q)
      );

      assign irq = |(cap_q & mask_q);
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

endmodule

// File: rtl/gpio_cap_chk.sv
module gpio_cap_chk
   import gpio_cap_pkg::*;
#(
   parameter int    N      = 32,
   parameter int    ADDR_W = 4,
   parameter trig_e MODE   = TRIG_RISE
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              reg_we,
   input logic [31:0]       reg_wdata,
   input logic              reg_re,
   input logic [31:0]       reg_rdata,
   input logic [N-1:0]      pin_oe,
   input logic              irq,
   input logic [N-1:0]      mask_q,
   input logic [N-1:0]      cap_q,
   input logic [N-1:0]      edge_hit
);

   localparam logic [31:0] LOW_BITS = 32'((64'd1 << N) - 64'd1);

   logic at_dir, at_mask, at_cap;
   assign at_dir  = (reg_addr == ADDR_W'(OFF_DIR));
   assign at_mask = (reg_addr == ADDR_W'(OFF_MASK));
   assign at_cap  = (reg_addr == ADDR_W'(OFF_CAP));

   assert_dir_drives_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && at_dir) |=> (pin_oe == $past(reg_wdata[N-1:0])));

   assert_mask_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_re && at_mask) |=> (reg_rdata == 32'($past(mask_q))));

   assert_upper_bits_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rdata & ~LOW_BITS) == 32'd0));

   assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);

   if (MODE == TRIG_LEVEL) begin : g_level_chk
      assert_level_cap_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (reg_re && at_cap) |=> (reg_rdata == 32'd0));
   end else begin : g_edge_chk
      assert_capture_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
         !(reg_we && at_cap) |=> ((cap_q & $past(cap_q)) == $past(cap_q)));

      assert_edge_sets_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (edge_hit != '0) |=> ((cap_q & $past(edge_hit)) == $past(edge_hit)));
   end

endmodule

bind gpio_cap gpio_cap_chk #(.N(N), .ADDR_W(ADDR_W), .MODE(MODE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_we    (reg_we),
   .reg_wdata (reg_wdata),
   .reg_re    (reg_re),
   .reg_rdata (reg_rdata),
   .pin_oe    (pin_oe),
   .irq       (irq),
   .mask_q    (mask_q),
   .cap_q     (cap_q),
   .edge_hit  (edge_hit)
);

// File: tb/gpio_cap_bench.sv
module gpio_cap_bench;
   import gpio_cap_pkg::*;

   localparam int NP = 20;
   localparam int NM = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic          re = 1'b0;
   logic [NP-1:0] pin_in = '0;

   logic [31:0]   rdata [NM];
   logic          irq_o [NM];
   logic [NP-1:0] pout  [NM];
   logic [NP-1:0] poe   [NM];

   always #2 clk = ~clk;

   for (genvar m = 0; m < NM; m++) begin : g_mode
      gpio_cap #(.N(NP), .ADDR_W(4), .MODE(trig_e'(m))) u_gpio_cap (
         .clk       (clk),
         .rst_n     (rst_n),
         .reg_addr  (addr),
         .reg_we    (we),
         .reg_wdata (wdata),
         .reg_re    (re),
         .reg_rdata (rdata[m]),
         .pin_in    (pin_in),
         .pin_out   (pout[m]),
         .pin_oe    (poe[m]),
         .irq       (irq_o[m])
      );
   end

   // reference model, built from the requirements
   logic [NP-1:0] m_out [NM], m_dir [NM], m_mask [NM], m_cap [NM];
   logic [31:0]   m_rd [NM];
   logic [NP-1:0] m_s1, m_s2, m_prev;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  mon_en = 1'b0;
   bit  done = 1'b0;
   logic [31:0] rd_v [NM];

   function automatic logic [NP-1:0] f_edge(input int mode, input logic [NP-1:0] cur,
                                            input logic [NP-1:0] prv);
      case (mode)
         0:       return cur & ~prv;
         1:       return ~cur & prv;
         2:       return cur ^ prv;
         default: return '0;
      endcase
   endfunction

   function automatic logic [31:0] f_read(input int m, input logic [3:0] a);
      logic [NP-1:0] v;
      case (a)
         4'h0:    v = (m_dir[m] & m_out[m]) | (~m_dir[m] & m_s2);
         4'h4:    v = m_dir[m];
         4'h8:    v = m_mask[m];
         4'hC:    v = m_cap[m];
         default: v = '0;
      endcase
      return 32'(v);
   endfunction

   function automatic logic f_irq(input int m);
      if (m == 3) return |(m_s2 & m_mask[m]);
      return |(m_cap[m] & m_mask[m]);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int m = 0; m < NM; m++) begin
            m_out[m] = '0; m_dir[m] = '0; m_mask[m] = '0; m_cap[m] = '0; m_rd[m] = '0;
         end
         m_s1 = '0; m_s2 = '0; m_prev = '0;
      end else begin
         for (int m = 0; m < NM; m++) begin
            logic [NP-1:0] e, clr;
            e   = f_edge(m, m_s2, m_prev);
            clr = (we && addr == 4'hC) ? wdata[NP-1:0] : '0;
            if (re) m_rd[m] = f_read(m, addr);
            if (m != 3) m_cap[m] = e | (m_cap[m] & ~clr);
            if (we) begin
               if (addr == 4'h0) m_out[m]  = wdata[NP-1:0];
               if (addr == 4'h4) m_dir[m]  = wdata[NP-1:0];
               if (addr == 4'h8) m_mask[m] = wdata[NP-1:0];
            end
         end
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pin_in;
      end
   end

   task automatic chk(input string tag, input int m, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s mode%0d: got %h expected %h", tag, m, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mon_en && rst_n) begin
         for (int m = 0; m < NM; m++) begin
            chk("R2 rdata", m, rdata[m], m_rd[m]);
            chk((m == 3) ? "R9 irq" : "R8 irq", m, 32'(irq_o[m]), 32'(f_irq(m)));
            chk("R3 pin_oe", m, 32'(poe[m]), 32'(m_dir[m]));
            chk("R3 pin_out", m, 32'(pout[m]), 32'(m_out[m]));
         end
      end
   end

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1; re = 1'b0;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a);
      @(negedge clk);
      addr = a; re = 1'b1; we = 1'b0;
      @(negedge clk);
      re = 1'b0;
      for (int m = 0; m < NM; m++) rd_v[m] = rdata[m];
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk_modes(input string tag, input logic [31:0] e0, input logic [31:0] e1,
                            input logic [31:0] e2, input logic [31:0] e3);
      chk(tag, 0, rd_v[0], e0);
      chk(tag, 1, rd_v[1], e1);
      chk(tag, 2, rd_v[2], e2);
      chk(tag, 3, rd_v[3], e3);
   endtask

   task automatic chk_irq(input string tag, input logic e0, input logic e1,
                          input logic e2, input logic e3);
      chk(tag, 0, 32'(irq_o[0]), 32'(e0));
      chk(tag, 1, 32'(irq_o[1]), 32'(e1));
      chk(tag, 2, 32'(irq_o[2]), 32'(e2));
      chk(tag, 3, 32'(irq_o[3]), 32'(e3));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      idle(4);
      // R1: state during and right after reset
      for (int m = 0; m < NM; m++) begin
         chk("R1 reset irq", m, 32'(irq_o[m]), 32'd0);
         chk("R1 reset pin_oe", m, 32'(poe[m]), 32'd0);
         chk("R1 reset rdata", m, rdata[m], 32'd0);
      end
      rst_n = 1'b1;
      mon_en = 1'b1;
      idle(2);
      bus_rd(4'h0); chk_modes("R1 data", 0, 0, 0, 0);
      bus_rd(4'h4); chk_modes("R1 dir", 0, 0, 0, 0);
      bus_rd(4'h8); chk_modes("R1 mask", 0, 0, 0, 0);
      bus_rd(4'hC); chk_modes("R1 cap", 0, 0, 0, 0);

      // R10: bits above the pin count
      bus_wr(4'h4, 32'hFFFF_FFFF);
      bus_rd(4'h4); chk_modes("R10 dir", 32'h000F_FFFF, 32'h000F_FFFF, 32'h000F_FFFF, 32'h000F_FFFF);
      chk("R3 oe all", 0, 32'(poe[0]), 32'h000F_FFFF);

      // R4: mixed direction read
      bus_wr(4'h0, 32'h0000_00A5);
      bus_wr(4'h4, 32'h0000_000F);
      pin_in = 20'h5A5A0;
      idle(3);
      bus_rd(4'h0); chk_modes("R4 data", 32'h0005_A5A5, 32'h0005_A5A5, 32'h0005_A5A5, 32'h0005_A5A5);
      chk("R3 pin_out", 0, 32'(pout[0]), 32'h0000_00A5);
      bus_wr(4'h4, 32'h0);
      pin_in = '0;
      idle(4);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      idle(2);

      // R5, R6: edges on bit 3
      pin_in = 20'h00008;
      idle(4);
      bus_rd(4'hC); chk_modes("R5 rise", 32'h8, 32'h0, 32'h8, 32'h0);
      pin_in = '0;
      idle(4);
      bus_rd(4'hC); chk_modes("R5 fall", 32'h8, 32'h8, 32'h8, 32'h0);
      bus_wr(4'hC, 32'h0);
      bus_rd(4'hC); chk_modes("R6 write zero", 32'h8, 32'h8, 32'h8, 32'h0);
      bus_wr(4'hC, 32'h8);
      bus_rd(4'hC); chk_modes("R6 clear", 32'h0, 32'h0, 32'h0, 32'h0);

      // R11, R8, R9: interrupt gating
      pin_in = 20'h00008;
      idle(4);
      chk_irq("R11 masked", 0, 0, 0, 0);
      bus_wr(4'h8, 32'h8);
      chk_irq("R8 R9 unmasked", 1, 0, 1, 1);
      pin_in = '0;
      idle(4);
      chk_irq("R8 R9 after fall", 1, 1, 1, 0);
      bus_wr(4'h8, 32'h0);
      chk_irq("R11 remasked", 0, 0, 0, 0);
      bus_wr(4'hC, 32'hFFFF_FFFF);
      bus_rd(4'hC); chk_modes("R9 cap cleared", 0, 0, 0, 0);

      // R7: edge and clear collide on bit 0
      idle(4);
      pin_in = 20'h00001;
      @(negedge clk);
      @(negedge clk);
      addr = 4'hC; wdata = 32'h1; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
      bus_rd(4'hC); chk_modes("R7 edge wins", 32'h1, 32'h0, 32'h1, 32'h0);

      // R2: unmapped address
      bus_wr(4'h2, 32'hFFFF_FFFF);
      bus_rd(4'h4); chk_modes("R2 unmapped write", 0, 0, 0, 0);
      bus_rd(4'h2); chk_modes("R2 unmapped read", 0, 0, 0, 0);

      // random mix, checked by the model every cycle
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         we = ($urandom % 10) < 3;
         re = ($urandom % 2) == 1;
         case ($urandom % 5)
            0: addr = 4'h0;
            1: addr = 4'h4;
            2: addr = 4'h8;
            3: addr = 4'hC;
            default: addr = 4'($urandom);
         endcase
         wdata = $urandom;
         if (($urandom % 3) == 0) pin_in = pin_in ^ (NP'(1) << ($urandom % NP));
         if (($urandom % 200) == 0) pin_in = NP'($urandom);
      end
      @(negedge clk);
      we = 1'b0; re = 1'b0;
      idle(4);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule